// File: doc/BRIEF.md
# Vectored Interrupt Controller with Priority Chain

This block is a small byte-wide, register-mapped interrupt controller that arbitrates between one external interrupt line and one timer expiry. Software writes a 16-bit vector into two byte registers and picks, through a two-bit control code, which single source may raise a request. When the chosen source fires, a request flip-flop is set. While the flip-flop is set, the source is still enabled and the active-low priority input of the daisy chain is low, the block raises its request output and presents the vector. Bit 7 of that vector is rewritten to show which source is behind the request.

The same register port feeds a separate timer. A write to the timer-load address passes the byte on to the timer through a one-cycle load strobe, and that same write clears the pending request. The counting itself happens outside this block, which only takes the timer's expiry pulse back. The external line is brought into the clock domain through a two-flop synchronizer and is edge-detected, so a line held low raises only one request.

Top module: `vic_irq_ctrl`

## Requirements
- R1: A write to address 0 stores the vector high byte and a write to address 1 stores the vector low byte. Reading either address returns the stored byte.
- R2: A read from address 2 or address 3 returns 0x00.
- R3: The control byte written to address 2 is decoded from bits[1:0]. Code 01 enables the external source only, code 11 enables the timer source only, and codes 00 and 10 enable neither. At no time are both sources enabled.
- R4: While a request is presented, the vector output equals {high, low} with bit 7 set to 1 if the external source is enabled and cleared to 0 if the timer source is enabled. While no request is presented, the vector output is 0x0000.
- R5: A falling edge on the active-low external input sets the request flip-flop only while the external source is enabled. The request output rises on the fourth rising clock edge after the input falls. A line held low does not set the flip-flop again, and an edge seen while the source is disabled leaves no pending request.
- R6: A timer expiry pulse sets the request flip-flop only while the timer source is enabled. The request output rises on the second rising clock edge from the edge that sampled the pulse. A pulse seen while the timer source is disabled leaves no pending request.
- R7: Any write to address 3 clears the request flip-flop, and the clear wins over a set in the same cycle. One cycle after the write, the timer load strobe is high for one cycle and the load data equals the written byte.
- R8: The request output is high only if the priority input was low at the previous clock edge. Raising the priority input drops the request on the next edge, and the pending flip-flop stays set, so the request comes back once the priority input returns low.
- R9: After reset both sources are disabled, the request flip-flop is clear, the request output and the vector output are 0, and the load strobe is low.
- R10: The request output needs the flip-flop and an enabled source at the same time. Switching the control code to one that enables no source drops the request and keeps the flip-flop set. Switching from one source to the other keeps the request and moves vector bit 7 to the source that is now enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regAddr | input | 2 | Register address (0 high, 1 low, 2 control, 3 timer load) |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the addressed register (combinational) |
| extIrqN | input | 1 | External interrupt, active low, asynchronous |
| prioInN | input | 1 | Priority-chain input, active low |
| timerExpire | input | 1 | One-cycle expiry pulse from the timer |
| irqReq | output | 1 | Interrupt request, registered |
| irqVector | output | 16 | Presented vector, registered, zero when idle |
| timerLoad | output | 1 | One-cycle load strobe to the timer |
| timerLoadData | output | 8 | Byte to load into the timer |

## Verification
The hardest state to reach from the ports is a pending flip-flop that sits hidden behind a disabled source or a high priority input, because the request output shows nothing about it. The bench exposes that state by going back to an enabling configuration and watching whether the request returns. It checks both outcomes: a flip-flop that was left set must bring the request back, and an event that should have been ignored must not. It also lines up a timer pulse with a write to address 3 on the same edge to show that the clear wins, and it holds the external line low across a clear to show that only an edge raises a request.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_VEC_HI = 2'd0,
    ADDR_VEC_LO = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_TMR    = 2'd3
  } regAddr_e;

  // Source-select codes in control bits[1:0]
  localparam logic [1:0] CODE_EXT_ONLY = 2'b01;
  localparam logic [1:0] CODE_TMR_ONLY = 2'b11;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrHi;
    logic wrLo;
    logic wrCtrl;
    logic wrTmr;
  } regStrobe_t;

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= RESET_VAL;
    else        chain[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= RESET_VAL;
      else        chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              extIrqN,
  input  logic              prioInN,
  input  logic              timerExpire,
  output regStrobe_t        strobe,
  output logic              extEn,
  output logic              tmrEn,
  output logic              reqFlop,
  output logic              reqLive,
  output logic              irqReq,
  output logic              timerLoad,
  output logic [DATA_W-1:0] timerLoadData
);

  logic extSync;
  logic extPrev;
  logic extFall;
  logic setReq;
  logic clrReq;

  // Address decode into strobes
  always_comb begin
    strobe        = '0;
    strobe.wrHi   = regWrEn && (regAddr == ADDR_VEC_HI);
    strobe.wrLo   = regWrEn && (regAddr == ADDR_VEC_LO);
    strobe.wrCtrl = regWrEn && (regAddr == ADDR_CTRL);
    strobe.wrTmr  = regWrEn && (regAddr == ADDR_TMR);
  end

  // External line: synchronize, then detect a falling edge
  vic_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_extSync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (extIrqN),
    .dout (extSync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) extPrev <= 1'b1;
    else        extPrev <= extSync;
  end

  assign extFall = extPrev & ~extSync;

  // Source enables: exactly one or none
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      extEn <= 1'b0;
      tmrEn <= 1'b0;
    end else if (strobe.wrCtrl) begin
      extEn <= (regWrData[1:0] == CODE_EXT_ONLY);
      tmrEn <= (regWrData[1:0] == CODE_TMR_ONLY);
    end
  end

  // Request flip-flop: clear has priority
  assign setReq = (extFall & extEn) | (timerExpire & tmrEn);
  assign clrReq = strobe.wrTmr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reqFlop <= 1'b0;
    else if (clrReq) reqFlop <= 1'b0;
    else if (setReq) reqFlop <= 1'b1;
  end

  assign reqLive = reqFlop & (extEn | tmrEn) & ~prioInN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqReq <= 1'b0;
    else        irqReq <= reqLive;
  end

  // Pass-through to the timer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timerLoad     <= 1'b0;
      timerLoadData <= '0;
    end else begin
      timerLoad <= strobe.wrTmr;
      if (strobe.wrTmr) timerLoadData <= regWrData;
    end
  end

endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SRC_BIT = 7,
  localparam int VEC_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  regStrobe_t        strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              reqLive,
  input  logic              extEn,
  output logic [DATA_W-1:0] regRdData,
  output logic [VEC_W-1:0]  irqVector
);

  logic [DATA_W-1:0] vecHi;
  logic [DATA_W-1:0] vecLo;
  logic [VEC_W-1:0]  srcVector;

  // Vector bytes carry no reset value
  always_ff @(posedge clk) begin
    if (strobe.wrHi) vecHi <= regWrData;
    if (strobe.wrLo) vecLo <= regWrData;
  end

  always_comb begin
    case (regAddr)
      ADDR_VEC_HI: regRdData = vecHi;
      ADDR_VEC_LO: regRdData = vecLo;
      default:     regRdData = '0;
    endcase
  end

  always_comb begin
    srcVector          = {vecHi, vecLo};
    srcVector[SRC_BIT] = extEn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqVector <= '0;
    else        irqVector <= reqLive ? srcVector : '0;
  end

endmodule

// File: rtl/vic_irq_ctrl.sv
module vic_irq_ctrl
  import vic_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SRC_BIT     = 7,
  localparam int VEC_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              extIrqN,
  input  logic              prioInN,
  input  logic              timerExpire,
  output logic              irqReq,
  output logic [VEC_W-1:0]  irqVector,
  output logic              timerLoad,
  output logic [DATA_W-1:0] timerLoadData
);

  regStrobe_t strobe;
  logic       extEn;
  logic       tmrEn;
  logic       reqFlop;
  logic       reqLive;

  vic_ctrl #(
    .DATA_W     (DATA_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .regAddr      (regAddr),
    .regWrEn      (regWrEn),
    .regWrData    (regWrData),
    .extIrqN      (extIrqN),
    .prioInN      (prioInN),
    .timerExpire  (timerExpire),
    .strobe       (strobe),
    .extEn        (extEn),
    .tmrEn        (tmrEn),
    .reqFlop      (reqFlop),
    .reqLive      (reqLive),
    .irqReq       (irqReq),
    .timerLoad    (timerLoad),
    .timerLoadData(timerLoadData)
  );

  vic_datapath #(
    .DATA_W (DATA_W),
    .SRC_BIT(SRC_BIT)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .reqLive  (reqLive),
    .extEn    (extEn),
    .regRdData(regRdData),
    .irqVector(irqVector)
  );

endmodule

// File: rtl/vic_irq_ctrl_checker.sv
module vic_irq_ctrl_checker #(
  parameter int DATA_W  = 8,
  parameter int SRC_BIT = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          regAddr,
  input logic                regWrEn,
  input logic [DATA_W-1:0]   regWrData,
  input logic                prioInN,
  input logic                irqReq,
  input logic [2*DATA_W-1:0] irqVector,
  input logic                timerLoad,
  input logic [DATA_W-1:0]   timerLoadData,
  input logic                extEn,
  input logic                tmrEn,
  input logic                reqFlop
);

  assert_enables_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({extEn, tmrEn}));

  assert_vec_src_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> (irqVector[SRC_BIT] == $past(extEn)));

  assert_vec_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irqReq |-> (irqVector == '0));

  // R5 and R6: the flip-flop only rises while a source is enabled
  assert_set_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reqFlop) |-> $past(extEn || tmrEn));

  assert_clear_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == 2'd3) |=> ##1 !irqReq);

  assert_load_follows_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timerLoad |-> $past(regWrEn && regAddr == 2'd3));

  assert_load_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timerLoad |-> (timerLoadData == $past(regWrData)));

  assert_req_needs_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> $past(!prioInN));

  assert_req_needs_flop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irqReq |-> $past(reqFlop && (extEn || tmrEn)));

endmodule

bind vic_irq_ctrl vic_irq_ctrl_checker #(
  .DATA_W (DATA_W),
  .SRC_BIT(SRC_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .regAddr      (regAddr),
  .regWrEn      (regWrEn),
  .regWrData    (regWrData),
  .prioInN      (prioInN),
  .irqReq       (irqReq),
  .irqVector    (irqVector),
  .timerLoad    (timerLoad),
  .timerLoadData(timerLoadData),
  .extEn        (extEn),
  .tmrEn        (tmrEn),
  .reqFlop      (reqFlop)
);

// File: tb/vic_irq_ctrl_bench.sv
module vic_irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  regAddr;
  logic        regWrEn;
  logic [7:0]  regWrData;
  logic [7:0]  regRdData;
  logic        extIrqN;
  logic        prioInN;
  logic        timerExpire;
  logic        irqReq;
  logic [15:0] irqVector;
  logic        timerLoad;
  logic [7:0]  timerLoadData;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_irq_ctrl u_vic_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .extIrqN(extIrqN),
    .prioInN(prioInN), .timerExpire(timerExpire), .irqReq(irqReq),
    .irqVector(irqVector), .timerLoad(timerLoad), .timerLoadData(timerLoadData)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Write spans one rising edge; returns at the following falling edge
  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic timerPulse();
    timerExpire = 1'b1;
    tick(1);
    timerExpire = 1'b0;
  endtask

  task automatic testReset();
    check("R9", "irqReq after reset", irqReq, 0);
    check("R9", "vector after reset", irqVector, 0);
    check("R9", "timerLoad after reset", timerLoad, 0);
    // enables clear: a timer pulse leaves nothing behind once enabled
    timerPulse();
    regWrite(2'd2, 8'h03);
    tick(2);
    check("R9", "no pending request after reset", irqReq, 0);
    regWrite(2'd2, 8'h00);
  endtask

  task automatic testRegs();
    logic [7:0] d;
    regWrite(2'd0, 8'hA5);
    regWrite(2'd1, 8'h3C);
    regRead(2'd0, d); check("R1", "high byte readback", d, 8'hA5);
    regRead(2'd1, d); check("R1", "low byte readback", d, 8'h3C);
    regWrite(2'd2, 8'hFF);
    regRead(2'd2, d); check("R2", "control reads zero", d, 8'h00);
    regRead(2'd3, d); check("R2", "timer addr reads zero", d, 8'h00);
    regWrite(2'd2, 8'h00);
  endtask

  task automatic testTimer();
    regWrite(2'd2, 8'h03);
    timerPulse();
    check("R6", "no request one edge after pulse", irqReq, 0);
    tick(1);
    check("R6", "timer request", irqReq, 1);
    check("R4", "timer vector bit7 cleared", irqVector, 16'hA53C);
    regWrite(2'd3, 8'h5A);
    check("R7", "load strobe", timerLoad, 1);
    check("R7", "load data", timerLoadData, 8'h5A);
    tick(1);
    check("R7", "request cleared", irqReq, 0);
    check("R7", "load strobe one cycle", timerLoad, 0);
    check("R4", "vector zero when idle", irqVector, 0);
  endtask

  task automatic testExt();
    regWrite(2'd2, 8'h01);
    extIrqN = 1'b0;
    tick(3);
    check("R5", "no request after three edges", irqReq, 0);
    tick(1);
    check("R5", "external request", irqReq, 1);
    check("R4", "external vector bit7 set", irqVector, 16'hA5BC);
    regWrite(2'd3, 8'h11);
    tick(6);
    check("R5", "held-low line gives no new request", irqReq, 0);
    extIrqN = 1'b1;
    tick(3);
  endtask

  task automatic testPriority();
    regWrite(2'd2, 8'h03);
    timerPulse();
    tick(1);
    check("R8", "request with priority low", irqReq, 1);
    prioInN = 1'b1;
    tick(1);
    check("R8", "request drops with priority high", irqReq, 0);
    check("R8", "vector zero with priority high", irqVector, 0);
    tick(3);
    check("R8", "request held off", irqReq, 0);
    prioInN = 1'b0;
    tick(1);
    check("R8", "request returns", irqReq, 1);
    regWrite(2'd3, 8'h00);
    tick(1);
  endtask

  task automatic testClearWins();
    regWrite(2'd2, 8'h03);
    timerExpire = 1'b1;
    regWrite(2'd3, 8'h22);
    timerExpire = 1'b0;
    tick(2);
    check("R7", "clear wins over simultaneous set", irqReq, 0);
  endtask

  task automatic testIgnored();
    regWrite(2'd2, 8'h00);
    timerPulse();
    regWrite(2'd2, 8'h03);
    tick(2);
    check("R6", "pulse while disabled ignored", irqReq, 0);
    extIrqN = 1'b0; tick(4);
    extIrqN = 1'b1; tick(3);
    regWrite(2'd2, 8'h01);
    tick(2);
    check("R5", "edge while disabled ignored", irqReq, 0);
  endtask

  task automatic testSwitch();
    regWrite(2'd1, 8'hC3);
    regWrite(2'd2, 8'h01);
    extIrqN = 1'b0; tick(4);
    check("R10", "external request", irqReq, 1);
    check("R4", "external vector second pattern", irqVector, 16'hA5C3);
    extIrqN = 1'b1;
    regWrite(2'd2, 8'h03);
    tick(1);
    check("R10", "request kept after switch", irqReq, 1);
    check("R10", "vector follows timer source", irqVector, 16'hA543);
    regWrite(2'd2, 8'h02);
    tick(1);
    check("R3", "code 10 drops request", irqReq, 0);
    regWrite(2'd2, 8'h03);
    tick(1);
    check("R10", "flip-flop retained", irqReq, 1);
    regWrite(2'd2, 8'h00);
    tick(1);
    check("R3", "code 00 drops request", irqReq, 0);
    regWrite(2'd3, 8'h00);
    tick(1);
  endtask

  initial begin
    rst_n = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0;
    extIrqN = 1'b1; prioInN = 1'b0; timerExpire = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    testReset();
    testRegs();
    testTimer();
    testExt();
    testPriority();
    testClearWins();
    testIgnored();
    testSwitch();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule